// File: doc/BRIEF.md
# Stall-Time Fairness Policy Selector

This block watches a set of hardware threads that share a memory scheduler. For each thread it keeps two counters. One counts the cycles the thread is stalled on an outstanding memory access while running alongside the others. The other counts the cycles of delay that other threads caused it. From these two counts it estimates how long the thread would have stalled if it had run alone. It then forms a weighted slowdown for every thread that currently has a request the scheduler could legally issue.

Each cycle the block compares the spread of those slowdowns (largest over smallest) with a threshold held in a register that software writes. If the spread is below the threshold, it tells the scheduler to run its throughput-oriented priority. Otherwise it selects the fairness-oriented priority and names the thread with the largest weighted slowdown. In that mode the scheduler serves that thread first, then row hits, then the oldest request. All ratio tests are done by cross-multiplying fixed-width counters, so the block needs no divider.

Top module: `stf_policy_sel`

## Requirements
- R1: Reset sets all counters to zero, `mode_o` to 0, `top_o` to 0 and the threshold register to 0x18 (1.5). A high `clr` zeroes every counter at the next edge and takes priority over any count that cycle. It leaves the threshold unchanged.
- R2: A thread's shared-stall counter grows by one on each edge where its `stall_i` bit is high and `clr` is low.
- R3: A thread's interference counter grows by one for each of its `row_conf_i` and `bank_conf_i` bits that is high at an edge. Both bits high add two.
- R4: Both counters saturate at 2^CW-1 and never wrap.
- R5: The alone estimate is the shared count minus the interference count. When that difference is zero or negative, the estimate is 1.
- R6: The weighted slowdown of thread t is weight_t × shared_t / alone_t, with weight_t taken from `weight_i[t*WW +: WW]`. `top_o` is the eligible thread (`legal_i` bit high) with the largest weighted slowdown. On a tie the lowest index wins. With no eligible thread, `top_o` is 0.
- R7: `mode_o` is 1 (fairness) exactly when all three of these hold: at least two threads are eligible, the largest slowdown numerator is nonzero, and 16·Nmax·Dmin ≥ TH·Dmax·Nmin. Here N/D are the numerator and alone estimate of the largest and smallest eligible slowdowns, and TH is the threshold with 4 fractional bits. Otherwise `mode_o` is 0 (throughput).
- R8: A high `th_we_i` at an edge loads `th_d_i` into the threshold register. The decision made at that same edge still uses the old value.
- R9: With fewer than two eligible threads, `mode_o` is 0 whatever the counters hold.
- R10: `mode_o` and `top_o` are registered. After an edge they reflect the counter values that held before that edge, together with `legal_i`, `weight_i` and the threshold sampled at it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Synchronous clear of all counters |
| stall_i | input | NT | Per-thread stalled-on-memory flag |
| row_conf_i | input | NT | Per-thread pulse: lost row hit due to another thread |
| bank_conf_i | input | NT | Per-thread pulse: bank or bus conflict caused by another thread |
| legal_i | input | NT | Per-thread has-legal-request flag |
| weight_i | input | NT*WW | Per-thread priority weight, packed |
| th_we_i | input | 1 | Threshold register write enable |
| th_d_i | input | TW | Threshold write data, 4 fractional bits |
| mode_o | output | 1 | 0 = throughput priority, 1 = fairness priority |
| top_o | output | IW | Index of the thread with the largest weighted slowdown |

## Verification
Two functions can land on one edge. A threshold write can coincide with a decision, and a counter clear can coincide with new stall and interference pulses. The random traffic phase writes new thresholds while threads stall and conflict, and `clr` is pulsed while every input is busy. The behavioural model evaluates the decision with the pre-edge threshold and counters, then applies the write and the clear with priority. A mismatch on either output in the following cycle is reported against the requirement the phase exercises.

// File: rtl/stf_pkg.sv
package stf_pkg;
  typedef enum logic {
    MODE_THRU = 1'b0,
    MODE_FAIR = 1'b1
  } mode_e;
endpackage

// File: rtl/stf_thread_ctr.sv
module stf_thread_ctr #(
  parameter int CW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          stall,
  input  logic          ev_row,
  input  logic          ev_bank,
  output logic [CW-1:0] sh,
  output logic [CW-1:0] itf,
  output logic [CW-1:0] alone
);
  localparam logic [CW-1:0] MAXV = '1;
  localparam logic [CW-1:0] ONE  = CW'(1);

  logic [CW:0] sh_n, it_n;

  always_comb begin
    sh_n = {1'b0, sh} + (CW+1)'(stall);
    it_n = {1'b0, itf} + (CW+1)'(ev_row) + (CW+1)'(ev_bank);
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      sh  <= '0;
      itf <= '0;
    end else begin
      sh  <= sh_n[CW] ? MAXV : sh_n[CW-1:0];
      itf <= it_n[CW] ? MAXV : it_n[CW-1:0];
    end
  end

  // clamp: interference at or above shared stall leaves an estimate of 1
  assign alone = (itf >= sh) ? ONE : (sh - itf);

  a_r2_sh_step: assert property (@(posedge clk) disable iff (rst)
    (!clr && stall && sh != MAXV) |=> (sh == $past(sh) + ONE));

  a_r4_sh_sat: assert property (@(posedge clk) disable iff (rst)
    (!clr && sh == MAXV) |=> (sh == MAXV));

  a_r4_itf_sat: assert property (@(posedge clk) disable iff (rst)
    (!clr && itf == MAXV) |=> (itf == MAXV));

  a_r1_clr: assert property (@(posedge clk) disable iff (rst)
    clr |=> (sh == '0 && itf == '0));

  a_r5_alone_nz: assert property (@(posedge clk) disable iff (rst)
    alone != '0);
endmodule

// File: rtl/stf_slowdown_cmp.sv
module stf_slowdown_cmp #(
  parameter int NT = 4,
  parameter int NW = 14,
  parameter int CW = 10,
  parameter int IW = 2,
  parameter int KW = 3
) (
  input  logic [NW-1:0] num [NT],
  input  logic [CW-1:0] den [NT],
  input  logic [NT-1:0] elig,
  output logic [IW-1:0] mx_i,
  output logic [NW-1:0] mx_n,
  output logic [CW-1:0] mx_d,
  output logic [NW-1:0] mn_n,
  output logic [CW-1:0] mn_d,
  output logic [KW-1:0] n_elig
);
  localparam int PW = NW + CW;

  always_comb begin
    logic found;
    found  = 1'b0;
    mx_i   = '0;
    mx_n   = '0;
    mx_d   = CW'(1);
    mn_n   = '0;
    mn_d   = CW'(1);
    n_elig = '0;
    for (int t = 0; t < NT; t++) begin
      if (elig[t]) begin
        n_elig = n_elig + KW'(1);
        if (!found) begin
          found = 1'b1;
          mx_i = IW'(t);
          mx_n = num[t];
          mx_d = den[t];
          mn_n = num[t];
          mn_d = den[t];
        end else begin
          if (PW'(num[t]) * PW'(mx_d) > PW'(mx_n) * PW'(den[t])) begin
            mx_i = IW'(t);
            mx_n = num[t];
            mx_d = den[t];
          end
          if (PW'(num[t]) * PW'(mn_d) < PW'(mn_n) * PW'(den[t])) begin
            mn_n = num[t];
            mn_d = den[t];
          end
        end
      end
    end
  end
endmodule

// File: rtl/stf_policy_sel.sv
module stf_policy_sel
  import stf_pkg::*;
#(
  parameter int NT = 4,
  parameter int CW = 10,
  parameter int WW = 4,
  parameter int TW = 8,
  parameter logic [TW-1:0] TH_RST = 8'h18,
  localparam int IW = (NT > 1) ? $clog2(NT) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic [NT-1:0]    stall_i,
  input  logic [NT-1:0]    row_conf_i,
  input  logic [NT-1:0]    bank_conf_i,
  input  logic [NT-1:0]    legal_i,
  input  logic [NT*WW-1:0] weight_i,
  input  logic             th_we_i,
  input  logic [TW-1:0]    th_d_i,
  output logic             mode_o,
  output logic [IW-1:0]    top_o
);
  localparam int NW = CW + WW;
  localparam int KW = $clog2(NT + 1);
  localparam int XW = NW + CW + TW + 4;

  logic [CW-1:0] sh    [NT];
  logic [CW-1:0] itf   [NT];
  logic [CW-1:0] alone [NT];
  logic [NW-1:0] num   [NT];
  logic [TW-1:0] th_q;

  for (genvar t = 0; t < NT; t++) begin : g_thr
    stf_thread_ctr #(.CW(CW)) i_ctr (
      .clk     (clk),
      .rst     (rst),
      .clr     (clr),
      .stall   (stall_i[t]),
      .ev_row  (row_conf_i[t]),
      .ev_bank (bank_conf_i[t]),
      .sh      (sh[t]),
      .itf     (itf[t]),
      .alone   (alone[t])
    );
    assign num[t] = NW'(weight_i[t*WW +: WW]) * NW'(sh[t]);
  end

  logic [IW-1:0] mx_i;
  logic [NW-1:0] mx_n, mn_n;
  logic [CW-1:0] mx_d, mn_d;
  logic [KW-1:0] n_elig;

  stf_slowdown_cmp #(.NT(NT), .NW(NW), .CW(CW), .IW(IW), .KW(KW)) i_cmp (
    .num    (num),
    .den    (alone),
    .elig   (legal_i),
    .mx_i   (mx_i),
    .mx_n   (mx_n),
    .mx_d   (mx_d),
    .mn_n   (mn_n),
    .mn_d   (mn_d),
    .n_elig (n_elig)
  );

  logic [XW-1:0] lhs, rhs;
  mode_e         mode_c;

  always_comb begin
    lhs = XW'(mx_n) * XW'(mn_d) * XW'(16);
    rhs = XW'(th_q) * XW'(mx_d) * XW'(mn_n);
    if (n_elig >= KW'(2) && mx_n != '0 && lhs >= rhs) mode_c = MODE_FAIR;
    else                                              mode_c = MODE_THRU;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      th_q   <= TH_RST;
      mode_o <= 1'b0;
      top_o  <= '0;
    end else begin
      if (th_we_i) th_q <= th_d_i;
      mode_o <= mode_c;
      top_o  <= mx_i;
    end
  end

  logic [NT-1:0] legal_q;
  always_ff @(posedge clk) begin
    if (rst) legal_q <= '0;
    else     legal_q <= legal_i;
  end

  a_r9_few_thru: assert property (@(posedge clk) disable iff (rst)
    ($countones(legal_i) < 2) |=> !mode_o);

  a_r6_top_legal: assert property (@(posedge clk) disable iff (rst)
    (legal_i != '0) |=> legal_q[top_o]);

  a_r6_top_zero: assert property (@(posedge clk) disable iff (rst)
    (legal_i == '0) |=> (top_o == '0));

  a_r8_th_load: assert property (@(posedge clk) disable iff (rst)
    th_we_i |=> (th_q == $past(th_d_i)));

  a_r8_th_hold: assert property (@(posedge clk) disable iff (rst)
    !th_we_i |=> $stable(th_q));
endmodule

// File: tb/test_stf_policy_sel.sv
module test_stf_policy_sel;
  localparam int NT = 4;
  localparam int CW = 10;
  localparam int WW = 4;
  localparam int TW = 8;
  localparam int IW = 2;
  localparam int MAXC = (1 << CW) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic clr = 1'b0;
  logic [NT-1:0] stall_i = '0, row_conf_i = '0, bank_conf_i = '0, legal_i = '0;
  logic [NT*WW-1:0] weight_i = '0;
  logic th_we_i = 1'b0;
  logic [TW-1:0] th_d_i = '0;
  logic mode_o;
  logic [IW-1:0] top_o;

  always #4 clk = ~clk;

  stf_policy_sel #(.NT(NT), .CW(CW), .WW(WW), .TW(TW)) i_stf_policy_sel (
    .clk(clk), .rst(rst), .clr(clr), .stall_i(stall_i), .row_conf_i(row_conf_i),
    .bank_conf_i(bank_conf_i), .legal_i(legal_i), .weight_i(weight_i),
    .th_we_i(th_we_i), .th_d_i(th_d_i), .mode_o(mode_o), .top_o(top_o)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  string phase = "R1";

  // behavioural reference model
  int sh [NT];
  int itf[NT];
  int thr;
  int exp_mode, exp_top;

  always @(posedge clk) begin
    if (rst) begin
      for (int t = 0; t < NT; t++) begin sh[t] = 0; itf[t] = 0; end
      thr = 24; exp_mode = 0; exp_top = 0;
    end else begin
      longint mxn, mxd, mnn, mnd, n, d;
      int cnt;
      cnt = 0; mxn = 0; mxd = 1; mnn = 0; mnd = 1; exp_top = 0;
      for (int t = 0; t < NT; t++) begin
        d = sh[t] - itf[t];
        if (d < 1) d = 1;
        n = longint'(weight_i[t*WW +: WW]) * sh[t];
        if (legal_i[t]) begin
          if (cnt == 0) begin
            mxn = n; mxd = d; mnn = n; mnd = d; exp_top = t;
          end else begin
            if (n * mxd > mxn * d) begin mxn = n; mxd = d; exp_top = t; end
            if (n * mnd < mnn * d) begin mnn = n; mnd = d; end
          end
          cnt++;
        end
      end
      exp_mode = (cnt >= 2 && mxn != 0 && 16 * mxn * mnd >= thr * mxd * mnn) ? 1 : 0;
      if (th_we_i) thr = th_d_i;
      for (int t = 0; t < NT; t++) begin
        if (clr) begin sh[t] = 0; itf[t] = 0; end
        else begin
          sh[t]  = sh[t] + stall_i[t];
          itf[t] = itf[t] + row_conf_i[t] + bank_conf_i[t];
          if (sh[t] > MAXC) sh[t] = MAXC;
          if (itf[t] > MAXC) itf[t] = MAXC;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      n_chk++;
      if (mode_o !== exp_mode[0] || top_o !== exp_top[IW-1:0]) begin
        n_fail++;
        $display("FAIL %s: mode=%0d top=%0d expected mode=%0d top=%0d at %0t",
                 phase, mode_o, top_o, exp_mode, exp_top, $time);
      end
    end
  end

  task automatic cycles(input int n, input int kind);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      clr = 1'b0; th_we_i = 1'b0;
      case (kind)
        0: begin // R2: one thread stalls
          stall_i = 4'b0001; row_conf_i = '0; bank_conf_i = '0;
          legal_i = '1; weight_i = {4'd1, 4'd1, 4'd1, 4'd1};
        end
        1: begin // R3: conflict pulses
          stall_i = $urandom; row_conf_i = $urandom; bank_conf_i = $urandom;
        end
        2: begin // R6 R7 R8 R10: random traffic with threshold writes
          stall_i = $urandom; row_conf_i = $urandom & $urandom;
          bank_conf_i = $urandom & $urandom; legal_i = $urandom;
          weight_i = $urandom;
          if (i % 97 == 0) begin th_we_i = 1'b1; th_d_i = $urandom; end
          if (i % 331 == 330) clr = 1'b1;
        end
        3: begin // R9: at most one eligible
          stall_i = $urandom; legal_i = (i % 5 == 0) ? 4'b0000 : (4'b0001 << (i % 4));
          weight_i = $urandom;
        end
        4: begin // R4: saturation
          stall_i = '1; row_conf_i = 4'b0100; bank_conf_i = 4'b0100;
          legal_i = '1; weight_i = $urandom;
        end
        default: begin // R5: interference exceeds stall
          stall_i = $urandom & $urandom; row_conf_i = $urandom; bank_conf_i = $urandom;
          legal_i = $urandom; weight_i = $urandom;
        end
      endcase
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    n_chk++; // R1: reset state
    if (mode_o !== 1'b0 || top_o !== '0) begin
      n_fail++;
      $display("FAIL R1: mode=%0d top=%0d expected mode=0 top=0", mode_o, top_o);
    end
    rst = 1'b0;
    phase = "R2";            cycles(60, 0);
    phase = "R3";            cycles(150, 1);
    phase = "R6 R7 R8 R10";  cycles(3000, 2);
    phase = "R9";            cycles(200, 3);
    phase = "R1 clr";
    @(negedge clk); clr = 1'b1; stall_i = '1; row_conf_i = '1; legal_i = '1;
    cycles(40, 1);
    phase = "R4";            cycles(1300, 4);
    phase = "R1 clr";
    @(negedge clk); clr = 1'b1;
    phase = "R5";            cycles(400, 5);
    phase = "R6 R7 R8 R10";  cycles(1500, 2);
    @(negedge clk);
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not end, expected completion");
    finish_run();
  end
endmodule